// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer that raises a vectored interrupt request. Software programs three registers through a small write/read port. The first is a timer control word holding the interrupt vector, the mode, the mask and the stored polarity and trigger bits. The second is a divide configuration that picks how many clock cycles make up one counter tick. The third is an initial count. The live counter value can be read through a fourth read-only location.

Writing a non-zero initial count loads the counter and restarts the prescaler. The counter then drops by one on every divided tick. When it steps from one to zero it expires. In periodic mode it reloads and keeps running, and in one-shot mode it stops at zero. An unmasked expiry sets a pending flag. That flag drives the request output with the programmed vector until the acknowledge input clears it. A third mode encoding is recognised only so that it can freeze and disarm the counter.

Top module: `loc_irq_timer`

## Requirements
- R1: After synchronous reset, the control word reads 0x0001_0000 (masked, one-shot, vector 0, not pending). The divide, initial and current count locations read 0, and irq_valid is low.
- R2: Register selects are 0 = control word, 1 = divide configuration, 2 = initial count, 3 = current count. The control word has the vector in bits 7:0, pending in bit 12, polarity in bit 13, trigger in bit 15, mask in bit 16 and mode in bits 18:17. Written fields read back. Bit 12 and all other bits ignore writes; the other bits read 0.
- R3: The divide code is {cfg[3], cfg[1], cfg[0]}. Code 7 gives one tick per clock, and code n < 7 gives one tick per 2<<n clocks (2 to 128). cfg[2] is stored but has no effect on timing.
- R4: A write to select 2 loads both the initial count and the counter, and restarts the prescaler. A non-zero value arms the counter, and zero leaves it stopped.
- R5: The counter decrements by one on each divided tick while armed, and never otherwise. Reads of select 3 return its live value, and writes to select 3 are ignored.
- R6: When an armed counter steps from 1 to 0 with mask (bit 16) clear, pending is set and irq_valid rises on the next cycle with irq_vector equal to bits 7:0. With mask set, pending stays unchanged.
- R7: On expiry, mode 01 (periodic) reloads the initial count. Mode 00 (one-shot) and 11 hold the counter at zero until the next initial-count write.
- R8: In mode 10 (deadline), the counter disarms, holds its value and cannot expire. An initial-count write in this mode loads the counter without arming it.
- R9: irq_ack clears pending on the next cycle, except when an unmasked expiry occurs in the same cycle, in which case pending stays set.
- R10: An initial-count write in the same cycle as an expiry wins: the counter takes the written value and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| irq_ack | input | 1 | Acknowledge, clears pending |
| irq_valid | output | 1 | Interrupt request, equal to pending |
| irq_vector | output | 8 | Programmed interrupt vector |

## Verification
Two pairs of events can land in one cycle: an expiry and an acknowledge, and an expiry and an initial-count write. The first pair is forced with a periodic count of one at divide-by-one while the acknowledge is held high, so that every cycle both sets and clears pending. The second pair is forced by rewriting the initial count on exactly the edge where the counter would step from one to zero. A behavioural model in the bench applies the stated priorities (set over clear, load over expiry) and is compared on every clock. A long random phase then mixes writes, acknowledges and divide changes to produce further collisions.

// File: rtl/loc_irq_timer_pkg.sv
// Shared types and field positions for the local interrupt countdown timer.
// Assumes a 32-bit register data path and an 8-bit vector.
package loc_irq_timer_pkg;

    localparam int VEC_W    = 8;
    localparam int MODE_LSB = 17;
    localparam int MASK_BIT = 16;
    localparam int TRIG_BIT = 15;
    localparam int POL_BIT  = 13;
    localparam int PEND_BIT = 12;
    localparam int CFG_W    = 4;

    typedef enum logic [1:0] {
        TM_ONESHOT  = 2'b00,
        TM_PERIODIC = 2'b01,
        TM_DEADLINE = 2'b10,
        TM_RSVD     = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_DIV  = 2'd1,
        RS_INIT = 2'd2,
        RS_CUR  = 2'd3
    } rsel_e;

    typedef struct packed {
        tmode_e             mode;
        logic               mask;
        logic               trig;
        logic               pol;
        logic [VEC_W-1:0]   vec;
    } ctrl_t;

endpackage

// File: rtl/ltmr_prescale.sv
// Clock prescaler: turns a 3-bit divide code into a tick strobe.
// Code 7 ticks every clock; code n ticks every 2<<n clocks.
// Assumes PRE_W is wide enough to hold the largest ratio (128).
module ltmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       tick
);
    localparam int CODES = 8;

    logic [PRE_W-1:0] ratio_tbl [CODES];
    logic [PRE_W-1:0] ratio;
    logic [PRE_W-1:0] pre_cnt;

    // Ratio per code, built from the code index.
    generate
        for (genvar g = 0; g < CODES; g++) begin : g_ratio
            if (g == CODES - 1) begin : g_one
                assign ratio_tbl[g] = PRE_W'(1);
            end else begin : g_pow
                assign ratio_tbl[g] = PRE_W'(2) << g;
            end
        end
    endgenerate

    assign ratio = ratio_tbl[code];
    // Greater-or-equal so that a ratio shrinking mid-count cannot stall.
    assign tick  = (pre_cnt >= (ratio - PRE_W'(1)));

    // Prescale counter: clears on restart or tick, else counts up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (restart || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ltmr_count.sv
// Countdown core: loads, decrements on tick, expires on the 1->0 step.
// Assumes load has priority over everything, then deadline mode.
module ltmr_count
    import loc_irq_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  tmode_e           mode,
    output logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] init_q,
    output logic             expire
);
    logic armed;
    logic at_one;

    assign at_one = (cur == CNT_W'(1));
    assign expire = armed && tick && at_one && !load && (mode != TM_DEADLINE);

    // Counter, reload value and armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            init_q <= '0;
            armed  <= 1'b0;
        end else if (load) begin
            cur    <= load_val;
            init_q <= load_val;
            armed  <= (load_val != '0) && (mode != TM_DEADLINE);
        end else if (mode == TM_DEADLINE) begin
            armed  <= 1'b0;
        end else if (armed && tick) begin
            if (at_one) begin
                if (mode == TM_PERIODIC) begin
                    cur <= init_q;
                end else begin
                    cur   <= '0;
                    armed <= 1'b0;
                end
            end else begin
                cur <= cur - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ltmr_regs.sv
// Register file: control word, divide configuration, pending flag, read mux.
// Assumes CNT_W >= 19 so the control word fits the data path.
module ltmr_regs
    import loc_irq_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] init_q,
    input  logic             expire,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] rd_data,
    output ctrl_t            ctrl_q,
    output logic [2:0]       div_code,
    output logic             load,
    output logic             pending
);
    logic [CFG_W-1:0] div_q;
    logic [CNT_W-1:0] ctrl_word;

    assign load     = wr_en && (wr_sel == RS_INIT);
    assign div_code = {div_q[3], div_q[1:0]};

    // Control word and divide configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: TM_ONESHOT, mask: 1'b1, trig: 1'b0, pol: 1'b0, vec: '0};
            div_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == RS_CTRL) begin
                ctrl_q.vec  <= wr_data[VEC_W-1:0];
                ctrl_q.pol  <= wr_data[POL_BIT];
                ctrl_q.trig <= wr_data[TRIG_BIT];
                ctrl_q.mask <= wr_data[MASK_BIT];
                ctrl_q.mode <= tmode_e'(wr_data[MODE_LSB +: 2]);
            end else if (wr_sel == RS_DIV) begin
                div_q <= wr_data[CFG_W-1:0];
            end
        end
    end

    // Pending flag: an unmasked expiry sets it and wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire && !ctrl_q.mask) begin
            pending <= 1'b1;
        end else if (irq_ack) begin
            pending <= 1'b0;
        end
    end

    // Control word image for reads.
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[VEC_W-1:0]        = ctrl_q.vec;
        ctrl_word[PEND_BIT]         = pending;
        ctrl_word[POL_BIT]          = ctrl_q.pol;
        ctrl_word[TRIG_BIT]         = ctrl_q.trig;
        ctrl_word[MASK_BIT]         = ctrl_q.mask;
        ctrl_word[MODE_LSB +: 2]    = ctrl_q.mode;
    end

    // Read multiplexer.
    always_comb begin
        unique case (rd_sel)
            RS_CTRL: rd_data = ctrl_word;
            RS_DIV:  rd_data = {{(CNT_W-CFG_W){1'b0}}, div_q};
            RS_INIT: rd_data = init_q;
            default: rd_data = cur;
        endcase
    end
endmodule

// File: rtl/loc_irq_timer.sv
// Top of the local interrupt countdown timer: register file, prescaler
// and countdown core. Assumes one clock domain and synchronous reset.
module loc_irq_timer
    import loc_irq_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    ctrl_t            ctrl_q;
    logic [2:0]       div_code;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             tick;
    logic             expire;
    logic             pending;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] init_q;

    assign load_val   = wr_data;
    assign irq_valid  = pending;
    assign irq_vector = ctrl_q.vec;

    ltmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .cur      (cur_q),
        .init_q   (init_q),
        .expire   (expire),
        .irq_ack  (irq_ack),
        .rd_data  (rd_data),
        .ctrl_q   (ctrl_q),
        .div_code (div_code),
        .load     (load),
        .pending  (pending)
    );

    ltmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .code    (div_code),
        .tick    (tick)
    );

    ltmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .mode     (ctrl_q.mode),
        .cur      (cur_q),
        .init_q   (init_q),
        .expire   (expire)
    );
endmodule

// File: rtl/loc_irq_timer_chk.sv
// Property checker for loc_irq_timer, attached through bind below.
module loc_irq_timer_chk
    import loc_irq_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_valid,
    input logic             irq_ack,
    input logic             expire,
    input logic             mask,
    input tmode_e           mode,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic             tick,
    input logic [CNT_W-1:0] cur
);
    // R6: an unmasked expiry raises the request next cycle
    a_r6_expiry_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mask) |=> irq_valid);

    // R9: acknowledge without a colliding expiry drops the request
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && !expire) |=> !irq_valid);

    // R10: a load always lands in the counter
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(load_val)));

    // R5: no tick and no load means no counter movement
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cur));

    // R8: deadline mode freezes the counter
    a_r8_deadline_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_DEADLINE && !load) |=> $stable(cur));

    // R7: one-shot stays at zero
    a_r7_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_ONESHOT && cur == '0 && !load) |=> (cur == '0));
endmodule

bind loc_irq_timer loc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid),
    .irq_ack   (irq_ack),
    .expire    (expire),
    .mask      (ctrl_q.mask),
    .mode      (ctrl_q.mode),
    .load      (load),
    .load_val  (load_val),
    .tick      (tick),
    .cur       (cur_q)
);

// File: tb/loc_irq_timer_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module loc_irq_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string req = "R1";

    // Reference model state
    logic [7:0]  m_vec;
    logic        m_pol, m_trig, m_mask, m_pend, m_arm;
    logic [1:0]  m_mode;
    logic [3:0]  m_div;
    logic [31:0] m_init, m_cur;
    int          m_pre;

    always #2 clk = ~clk;   // 250 MHz

    loc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic int ratio_of(logic [3:0] d);
        int c = {d[3], d[1:0]};
        return (c == 7) ? 1 : (2 << c);
    endfunction

    function automatic logic [31:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0: return {13'd0, m_mode, m_mask, m_trig, 1'b0, m_pol, m_pend, 4'd0, m_vec};
            2'd1: return {28'd0, m_div};
            2'd2: return m_init;
            default: return m_cur;
        endcase
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] expv, string what);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", r, what, act, expv);
        end
    endtask

    task automatic model_reset();
        m_vec = 0; m_pol = 0; m_trig = 0; m_mask = 1; m_pend = 0; m_arm = 0;
        m_mode = 0; m_div = 0; m_init = 0; m_cur = 0; m_pre = 0;
    endtask

    // One clock: advance the model from the held inputs, then compare.
    task automatic cyc();
        bit ld, tk, ex;
        logic [31:0] n_cur, n_init;
        logic n_arm, n_pend;
        int n_pre;
        ld = wr_en && wr_sel == 2'd2;
        tk = (m_pre >= ratio_of(m_div) - 1);
        ex = 0;
        n_cur = m_cur; n_init = m_init; n_arm = m_arm; n_pend = m_pend;
        n_pre = (ld || tk) ? 0 : m_pre + 1;
        if (ld) begin
            n_cur = wr_data; n_init = wr_data;
            n_arm = (wr_data != 0) && (m_mode != 2'b10);
        end else if (m_mode == 2'b10) begin
            n_arm = 0;
        end else if (m_arm && tk) begin
            if (m_cur == 1) begin
                ex = 1;
                if (m_mode == 2'b01) n_cur = m_init;
                else begin n_cur = 0; n_arm = 0; end
            end else n_cur = m_cur - 1;
        end
        if (ex && !m_mask) n_pend = 1;
        else if (irq_ack) n_pend = 0;
        @(posedge clk);
        if (wr_en && wr_sel == 2'd0) begin
            m_vec = wr_data[7:0]; m_pol = wr_data[13]; m_trig = wr_data[15];
            m_mask = wr_data[16]; m_mode = wr_data[18:17];
        end
        if (wr_en && wr_sel == 2'd1) m_div = wr_data[3:0];
        m_cur = n_cur; m_init = n_init; m_arm = n_arm; m_pend = n_pend; m_pre = n_pre;
        @(negedge clk);
        chk(req, rd_data, exp_rd(rd_sel), "rd_data");
        chk(req, {31'd0, irq_valid}, {31'd0, m_pend}, "irq_valid");
        chk(req, {24'd0, irq_vector}, {24'd0, m_vec}, "irq_vector");
    endtask

    task automatic wr(logic [1:0] s, logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset values
        req = "R1";
        rd_sel = 0; #0 chk("R1", rd_data, 32'h0001_0000, "reset ctrl");
        for (int s = 1; s < 4; s++) begin
            rd_sel = s[1:0]; #1 chk("R1", rd_data, 32'd0, "reset reg");
        end
        chk("R1", {31'd0, irq_valid}, 32'd0, "reset irq");
        // R2: readback, pending and unused bits ignore writes
        req = "R2"; rd_sel = 0;
        wr(2'd0, 32'h0002_BF3C);
        chk("R2", rd_data, 32'h0002_A03C, "ctrl readback");
        rd_sel = 1; wr(2'd1, 32'hFFFF_FFF4);
        chk("R2", rd_data, 32'h0000_0004, "div readback");
        // R3 + R4 + R6: one-shot, divide-by-one
        req = "R3"; wr(2'd1, 32'h0000_000B);
        wr(2'd0, 32'h0000_0051);
        req = "R4"; rd_sel = 3; wr(2'd2, 32'd5);
        req = "R6"; idle(8);
        chk("R6", {24'd0, irq_vector}, 32'h51, "vector");
        chk("R6", {31'd0, irq_valid}, 32'd1, "raised");
        // R5: writes to current count ignored
        req = "R5"; wr(2'd3, 32'd99);
        chk("R5", rd_data, 32'd0, "cur write ignored");
        // R9: ack clears
        req = "R9"; irq_ack = 1; cyc(); irq_ack = 0;
        chk("R9", {31'd0, irq_valid}, 32'd0, "ack clears");
        // R7: periodic at ratio 2 (cfg bit2 set, no effect)
        req = "R7"; wr(2'd1, 32'h4); wr(2'd0, 32'h0002_0022);
        wr(2'd2, 32'd3); irq_ack = 1; idle(20); irq_ack = 0; idle(7);
        // R9: collision, periodic count of one, ack held
        req = "R9"; wr(2'd1, 32'hB); wr(2'd2, 32'd1); irq_ack = 1; idle(6);
        chk("R9", {31'd0, irq_valid}, 32'd1, "set wins over ack");
        irq_ack = 0;
        // R3: ratio 128
        req = "R3"; irq_ack = 1; cyc(); irq_ack = 0;
        wr(2'd0, 32'h0000_0011); wr(2'd1, 32'hA); wr(2'd2, 32'd2); idle(300);
        // R6: masked periodic
        req = "R6"; irq_ack = 1; cyc(); irq_ack = 0;
        wr(2'd0, 32'h0003_0012); wr(2'd1, 32'hB); wr(2'd2, 32'd2); idle(10);
        chk("R6", {31'd0, irq_valid}, 32'd0, "masked");
        // R8: deadline freezes running counter, then load does not arm
        req = "R8"; wr(2'd0, 32'h0002_0013); wr(2'd2, 32'd9); idle(3);
        wr(2'd0, 32'h0004_0013); idle(5);
        chk("R8", rd_data, 32'd5, "frozen");
        wr(2'd2, 32'd4); idle(6);
        chk("R8", rd_data, 32'd4, "not armed");
        // R4: zero stops
        req = "R4"; wr(2'd0, 32'h0002_0013); wr(2'd2, 32'd6); idle(2);
        wr(2'd2, 32'd0); idle(5);
        chk("R4", rd_data, 32'd0, "zero stops");
        // R10: load on expiry edge
        req = "R10"; wr(2'd0, 32'h0000_0014); wr(2'd2, 32'd3); idle(2);
        wr(2'd2, 32'd7);
        chk("R10", {31'd0, irq_valid}, 32'd0, "no irq");
        chk("R10", rd_data, 32'd7, "load taken");
        // Random mix
        req = "R5";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 12;
            irq_ack = ($urandom % 4) == 0;
            rd_sel = 2'($urandom);
            wr_en = (r < 4); wr_sel = 2'(r);
            wr_data = (r == 2) ? ($urandom % 20) :
                      (r == 1) ? 32'($urandom % 16) : $urandom;
            cyc();
        end
        wr_en = 0; irq_ack = 0;
        done = 1;
        summary();
        $finish;
    end
endmodule